// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds two component predictors built from two-bit saturating counters. The first is a plain table looked up with the branch address alone. The second is a correlated table looked up with the branch address XORed with a register of recent branch outcomes. A third table of two-bit counters, also looked up with the branch address, picks which component's guess becomes the final prediction.

At fetch, the caller presents the low-order word-address bits of the branch and reads the final prediction in the same cycle. It also reads both component guesses, which it carries down the pipeline with the branch. When the branch resolves, the caller presents the address, the real outcome and those two recorded guesses for one cycle. Both components then train, the chooser moves if the components disagreed, and the outcome shifts into the history register.

Target generation and flush control are left to surrounding logic. The tables hold no tags, so branches whose index bits match share entries.

Top module: `tourney_dir_pred`

## Requirements
- R1: Every counter holds 0 (strong not-taken), 1 (weak not-taken), 2 (weak taken) or 3 (strong taken), and a counter predicts taken when its bit 1 is set (value 2 or 3). After reset, both component counters are 1, every chooser counter is 0 and the history is 0, so all four lookup outputs are 0.
- R2: A counter saturates: a taken outcome at 3 and a not-taken outcome at 0 leave it unchanged. From 3, two not-taken resolutions are needed before the prediction becomes not-taken. From 0, two taken resolutions are needed before it becomes taken.
- R3: The simple table has no tags and is indexed by the address alone. Training one index leaves the prediction at another index unchanged.
- R4: On each cycle with `rs_valid` high, the history register shifts left by one place and takes the outcome (1 taken, 0 not-taken) into bit 0. It holds when `rs_valid` is low.
- R5: The correlated table index is the address XOR the history, with the history zero-extended to the index width. Lookup uses the current history.
- R6: On every resolution, both component counters at their indices step one place toward the outcome, subject to R2. The correlated index is formed with the history value from before that resolution's shift.
- R7: The chooser entry at the address starts at 0, which selects the simple component. On a resolution where the recorded guesses differ, it steps up if the correlated guess matched the outcome and down otherwise. The correlated component is selected when the chooser's bit 1 is set, so two such steps from reset move a branch over.
- R8: When the recorded guesses agree, the chooser does not change. When `rs_valid` is low, no table and no history bit changes, whatever the other resolution inputs hold.
- R9: `lk_taken` equals `lk_corr_pred` when `lk_use_corr` is 1 and `lk_simple_pred` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_pc | input | IDX_W | Word-address bits of the branch being fetched |
| lk_taken | output | 1 | Final direction prediction, 1 = taken |
| lk_use_corr | output | 1 | 1 when the chooser selects the correlated component |
| lk_simple_pred | output | 1 | Guess of the address-indexed component |
| lk_corr_pred | output | 1 | Guess of the history-correlated component |
| rs_valid | input | 1 | A branch resolves this cycle |
| rs_pc | input | IDX_W | Word-address bits of the resolving branch |
| rs_taken | input | 1 | Real outcome, 1 = taken |
| rs_simple_pred | input | 1 | Simple-component guess recorded at lookup |
| rs_corr_pred | input | 1 | Correlated-component guess recorded at lookup |

## Verification
Assertions check on every cycle that counters hold at 3 and at 0, that an entry holds in any cycle with no write, and that the history shifts in exactly one outcome per resolution and holds otherwise. They also check that the chooser keeps its choice when the recorded guesses agree, and that a taken resolution never lowers a simple guess of taken. Only the bench's scenarios show the rest. These are the two-step hysteresis, the history reaching the correlated index, and a branch with an alternating outcome moving to the correlated component after repeated wrong simple guesses. The bench runs all of these against a model built from the requirements.

// File: rtl/tdp_pkg.sv
// Shared types and helpers for the tournament direction predictor.
// Assumes nothing beyond a two-bit counter encoding: 0,1 predict not-taken
// and 2,3 predict taken.
package tdp_pkg;

    typedef logic [1:0] ctr2_t;

    localparam ctr2_t CTR_STRONG_NT = 2'd0;
    localparam ctr2_t CTR_WEAK_NT   = 2'd1;
    localparam ctr2_t CTR_WEAK_T    = 2'd2;
    localparam ctr2_t CTR_STRONG_T  = 2'd3;

    // Move a counter one step toward the direction given, saturating at both ends.
    function automatic ctr2_t ctr_step(input ctr2_t cur, input logic up);
        ctr2_t nxt;
        nxt = cur;
        if (up && cur != CTR_STRONG_T)
            nxt = cur + 2'd1;
        else if (!up && cur != CTR_STRONG_NT)
            nxt = cur - 2'd1;
        return nxt;
    endfunction

    // Direction a counter stands for.
    function automatic logic ctr_says_taken(input ctr2_t cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/tdp_ctr_table.sv
// Table of 2**IDX_W two-bit saturating counters, with one asynchronous read
// port and one write port that steps a single entry up or down per cycle.
// Assumes at most one training write per cycle. Every entry returns to
// RST_VAL on a synchronous active-low reset.
module tdp_ctr_table #(
    parameter int            IDX_W   = 8,
    parameter tdp_pkg::ctr2_t RST_VAL = 2'd1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IDX_W-1:0]     rd_idx,
    output tdp_pkg::ctr2_t       rd_ctr,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic                 wr_up
);
    import tdp_pkg::*;

    localparam int DEPTH = 1 << IDX_W;

    ctr2_t mem [DEPTH];

    // Reset every entry, or step the addressed entry toward the outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= RST_VAL;
        end else if (wr_en) begin
            mem[wr_idx] <= ctr_step(mem[wr_idx], wr_up);
        end
    end

    // Lookup is combinational so the prediction is ready in the fetch cycle.
    assign rd_ctr = mem[rd_idx];

    // R2: upward training at the top leaves the entry at the top.
    a_r2_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_up && mem[wr_idx] == CTR_STRONG_T)
        |=> (mem[$past(wr_idx)] == CTR_STRONG_T));

    // R2: downward training at the bottom leaves the entry at the bottom.
    a_r2_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_up && mem[wr_idx] == CTR_STRONG_NT)
        |=> (mem[$past(wr_idx)] == CTR_STRONG_NT));

    // R8: with no write, the entry being looked up keeps its value.
    a_r8_hold_unwritten: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> (mem[$past(rd_idx)] == $past(mem[rd_idx])));

endmodule

// File: rtl/tdp_ghist.sv
// Global outcome history shift register. Each resolution shifts the outcome
// into bit 0, and the oldest outcome falls off the top.
// Assumes HIST_W >= 2.
module tdp_ghist #(
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              shift_bit,
    output logic [HIST_W-1:0] hist
);

    // Clear on reset, or shift one resolved outcome in.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hist <= '0;
        else if (shift_en)
            hist <= {hist[HIST_W-2:0], shift_bit};
    end

    // R4: a resolution brings its outcome into bit 0 and moves older bits up.
    a_r4_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (hist[0] == $past(shift_bit)
                      && hist[HIST_W-1:1] == $past(hist[HIST_W-2:0])));

    // R4: without a resolution the history holds.
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(hist));

endmodule

// File: rtl/tourney_dir_pred.sv
// Tournament conditional-branch direction predictor.
// Lookup: the address indexes the simple table and the chooser directly, and
// indexes the correlated table after an XOR with the zero-extended history.
// All three reads are combinational.
// Resolution: both components train toward the outcome. The chooser steps
// only when the recorded guesses differ. The history then shifts in the
// outcome. The correlated write index uses the history as it stands at
// resolution.
// Assumes 2 <= HIST_W <= IDX_W and at most one resolution per cycle.
module tourney_dir_pred #(
    parameter int IDX_W  = 8,
    parameter int HIST_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_pc,
    output logic             lk_taken,
    output logic             lk_use_corr,
    output logic             lk_simple_pred,
    output logic             lk_corr_pred,
    input  logic             rs_valid,
    input  logic [IDX_W-1:0] rs_pc,
    input  logic             rs_taken,
    input  logic             rs_simple_pred,
    input  logic             rs_corr_pred
);
    import tdp_pkg::*;

    localparam int PAD_W = IDX_W - HIST_W;

    logic [HIST_W-1:0] hist;
    logic [IDX_W-1:0]  hist_ext;
    logic [IDX_W-1:0]  lk_corr_idx;
    logic [IDX_W-1:0]  rs_corr_idx;
    ctr2_t             simple_ctr;
    ctr2_t             corr_ctr;
    ctr2_t             choose_ctr;
    logic              choose_wr;
    logic              choose_up;

    // Zero-extend the history to the index width when it is shorter.
    generate
        if (PAD_W > 0) begin : g_pad
            assign hist_ext = {{PAD_W{1'b0}}, hist};
        end else begin : g_nopad
            assign hist_ext = hist;
        end
    endgenerate

    // Correlated-table indices for the lookup and training ports.
    always_comb begin
        lk_corr_idx = lk_pc ^ hist_ext;
        rs_corr_idx = rs_pc ^ hist_ext;
    end

    // The chooser moves only on disagreement, toward the component that was right.
    always_comb begin
        choose_wr = rs_valid && (rs_simple_pred != rs_corr_pred);
        choose_up = (rs_corr_pred == rs_taken);
    end

    tdp_ghist #(.HIST_W(HIST_W)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (rs_valid),
        .shift_bit (rs_taken),
        .hist      (hist)
    );

    tdp_ctr_table #(.IDX_W(IDX_W), .RST_VAL(CTR_WEAK_NT)) u_simple (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (lk_pc),
        .rd_ctr (simple_ctr),
        .wr_en  (rs_valid),
        .wr_idx (rs_pc),
        .wr_up  (rs_taken)
    );

    tdp_ctr_table #(.IDX_W(IDX_W), .RST_VAL(CTR_WEAK_NT)) u_corr (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (lk_corr_idx),
        .rd_ctr (corr_ctr),
        .wr_en  (rs_valid),
        .wr_idx (rs_corr_idx),
        .wr_up  (rs_taken)
    );

    tdp_ctr_table #(.IDX_W(IDX_W), .RST_VAL(CTR_STRONG_NT)) u_choose (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (lk_pc),
        .rd_ctr (choose_ctr),
        .wr_en  (choose_wr),
        .wr_idx (rs_pc),
        .wr_up  (choose_up)
    );

    // Turn the counters into guesses and select the final prediction.
    always_comb begin
        lk_simple_pred = ctr_says_taken(simple_ctr);
        lk_corr_pred   = ctr_says_taken(corr_ctr);
        lk_use_corr    = choose_ctr[1];
        lk_taken       = lk_use_corr ? lk_corr_pred : lk_simple_pred;
    end

    // R8: a resolution whose guesses agree keeps this address's chooser choice.
    a_r8_choice_kept_on_agree: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && rs_simple_pred == rs_corr_pred && rs_pc == lk_pc)
        |=> (!$stable(lk_pc) || $stable(lk_use_corr)));

    // R6: taken training never lowers a simple guess of taken at the same address.
    a_r6_simple_trains_up: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && rs_taken && rs_pc == lk_pc && lk_simple_pred)
        |=> (!$stable(lk_pc) || lk_simple_pred));

endmodule

// File: tb/test_tourney_dir_pred.sv
module test_tourney_dir_pred;

    localparam int CLK_PERIOD = 10;
    localparam int IDX_W      = 8;
    localparam int HIST_W     = 8;
    localparam int DEPTH      = 1 << IDX_W;
    localparam int N_STIM     = 16;

    // Stimulus vectors {address, outcome}; expected outputs come from the model.
    localparam logic [8:0] STIM [N_STIM] = '{
        {8'h12, 1'b1}, {8'h12, 1'b1}, {8'h34, 1'b0}, {8'h12, 1'b0},
        {8'h56, 1'b1}, {8'h34, 1'b1}, {8'h12, 1'b1}, {8'h78, 1'b0},
        {8'h56, 1'b1}, {8'h9a, 1'b1}, {8'h34, 1'b0}, {8'h12, 1'b1},
        {8'h78, 1'b1}, {8'h56, 1'b0}, {8'h9a, 1'b1}, {8'h12, 1'b0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [IDX_W-1:0] lk_pc = '0;
    logic             lk_taken, lk_use_corr, lk_simple_pred, lk_corr_pred;
    logic             rs_valid = 1'b0;
    logic [IDX_W-1:0] rs_pc = '0;
    logic             rs_taken = 1'b0;
    logic             rs_simple_pred = 1'b0;
    logic             rs_corr_pred = 1'b0;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    // Reference model built from the requirements.
    int               m_simple [DEPTH];
    int               m_corr   [DEPTH];
    int               m_choose [DEPTH];
    logic [HIST_W-1:0] m_hist;

    tourney_dir_pred #(.IDX_W(IDX_W), .HIST_W(HIST_W)) i_tourney_dir_pred (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
        .lk_use_corr(lk_use_corr), .lk_simple_pred(lk_simple_pred),
        .lk_corr_pred(lk_corr_pred), .rs_valid(rs_valid), .rs_pc(rs_pc),
        .rs_taken(rs_taken), .rs_simple_pred(rs_simple_pred),
        .rs_corr_pred(rs_corr_pred)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int sat(input int c, input bit up);
        if (up) return (c < 3) ? c + 1 : 3;
        return (c > 0) ? c - 1 : 0;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        rs_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            m_simple[i] = 1;
            m_corr[i]   = 1;
            m_choose[i] = 0;
        end
        m_hist = '0;
    endtask

    // Present an address for lookup and let the combinational outputs settle.
    task automatic peek(input logic [IDX_W-1:0] pc);
        @(negedge clk);
        rs_valid = 1'b0;
        lk_pc = pc;
        #1;
    endtask

    // Resolve one branch with given recorded guesses, updating the model too.
    task automatic resolve(input logic [IDX_W-1:0] pc, input bit taken,
                           input bit sp, input bit cp);
        logic [IDX_W-1:0] ci;
        ci = pc ^ {{(IDX_W-HIST_W){1'b0}}, m_hist};
        rs_valid = 1'b1; rs_pc = pc; rs_taken = taken;
        rs_simple_pred = sp; rs_corr_pred = cp;
        @(posedge clk);
        #1 rs_valid = 1'b0;
        m_simple[pc] = sat(m_simple[pc], taken);
        m_corr[ci]   = sat(m_corr[ci], taken);
        if (sp != cp) m_choose[pc] = sat(m_choose[pc], cp == taken);
        m_hist = {m_hist[HIST_W-2:0], taken};
    endtask

    // Look up, check all four outputs against the model, then resolve.
    task automatic step(input logic [IDX_W-1:0] pc, input bit taken, input string req);
        logic [IDX_W-1:0] ci;
        bit sp, cp, uc;
        peek(pc);
        ci = pc ^ {{(IDX_W-HIST_W){1'b0}}, m_hist};
        sp = (m_simple[pc] >= 2);
        cp = (m_corr[ci] >= 2);
        uc = (m_choose[pc] >= 2);
        chk(req, "simple_pred", lk_simple_pred, sp);
        chk(req, "corr_pred", lk_corr_pred, cp);
        chk(req, "use_corr", lk_use_corr, uc);
        chk({req, " R9"}, "taken", lk_taken, uc ? cp : sp);
        resolve(pc, taken, sp, cp);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        bit hold_sp, hold_cp, hold_uc, hold_t;

        // R1: reset state.
        do_reset();
        peek(8'h33);
        chk("R1", "reset taken", lk_taken, 0);
        chk("R1", "reset simple", lk_simple_pred, 0);
        chk("R1", "reset corr", lk_corr_pred, 0);
        chk("R1", "reset use_corr", lk_use_corr, 0);

        // R3 R5 R6: the vector table, walked several times against the model.
        for (int rep = 0; rep < 6; rep++)
            for (int k = 0; k < N_STIM; k++)
                step(STIM[k][8:1], STIM[k][0], "R3 R5 R6");

        // R2: hysteresis and saturation at both ends.
        do_reset();
        for (int k = 0; k < 4; k++) step(8'h21, 1'b1, "R2");
        peek(8'h21);
        chk("R2", "saturated taken", lk_simple_pred, 1);
        step(8'h21, 1'b0, "R2");
        peek(8'h21);
        chk("R2", "one miss keeps taken", lk_simple_pred, 1);
        step(8'h21, 1'b0, "R2");
        peek(8'h21);
        chk("R2", "two misses flip", lk_simple_pred, 0);
        for (int k = 0; k < 4; k++) step(8'h21, 1'b0, "R2");
        step(8'h21, 1'b1, "R2");
        peek(8'h21);
        chk("R2", "one taken from floor", lk_simple_pred, 0);
        step(8'h21, 1'b1, "R2");
        peek(8'h21);
        chk("R2", "two taken from floor", lk_simple_pred, 1);

        // R3: another index is untouched by that training.
        peek(8'h22);
        chk("R3", "untrained index", lk_simple_pred, 0);

        // R4 R5: history 0x01 after one taken, so address 0x11 reads corr entry 0x10.
        do_reset();
        step(8'h10, 1'b1, "R4 R6");
        peek(8'h11);
        chk("R4 R5", "corr via history", lk_corr_pred, 1);
        chk("R3", "simple at 0x11", lk_simple_pred, 0);
        peek(8'h10);
        chk("R5", "corr entry 0x11 fresh", lk_corr_pred, 0);

        // R7: an alternating branch moves to the correlated component.
        do_reset();
        for (int k = 0; k < 20; k++) step(8'h40, (k % 2) == 0, "R7");
        peek(8'h40);
        chk("R7", "simple wrong", lk_simple_pred, 0);
        chk("R7", "corr right", lk_corr_pred, 1);
        chk("R7", "chooser moved", lk_use_corr, 1);
        chk("R7 R9", "final prediction", lk_taken, 1);

        // R8: with rs_valid low, other resolution inputs have no effect.
        hold_sp = lk_simple_pred; hold_cp = lk_corr_pred;
        hold_uc = lk_use_corr;    hold_t = lk_taken;
        @(negedge clk);
        rs_valid = 1'b0; rs_pc = 8'h40; rs_taken = 1'b0;
        rs_simple_pred = 1'b1; rs_corr_pred = 1'b0;
        repeat (5) @(posedge clk);
        peek(8'h40);
        chk("R8", "idle simple", lk_simple_pred, hold_sp);
        chk("R8", "idle corr", lk_corr_pred, hold_cp);
        chk("R8", "idle use_corr", lk_use_corr, hold_uc);
        chk("R8", "idle taken", lk_taken, hold_t);

        // R8: agreeing guesses, both wrong, leave the chooser alone.
        @(negedge clk);
        resolve(8'h40, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        resolve(8'h40, 1'b1, 1'b0, 1'b0);
        peek(8'h40);
        chk("R8", "chooser after agree", lk_use_corr, 1);

        // Model keeps tracking after the forced resolutions.
        for (int k = 0; k < 8; k++) step(8'h40, (k % 3) == 0, "R6 R7");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule